// File: doc/BRIEF.md
# Request/Acknowledge Byte Transceiver

This block moves one byte at a time between a host and a peripheral controller. The two sides share an 8-bit shift register, a direction line, an active-low request line driven by this block and an acknowledge line driven by the peripheral. The host presents a command: send a byte, or receive one. The block then sequences the handshake and reports completion with a one-cycle pulse. The pulse carries a result code and, for a receive, the captured byte.

Every transfer first confirms that the peripheral is free, which means acknowledge is high. A send drives the direction and data, pulls request low and waits for acknowledge to drop. Then it releases request. A receive turns the direction to input and pulls request low. It waits for acknowledge to drop and releases request. It then waits for acknowledge to rise again, and only then takes the shift register contents.

Each of these waits is bounded. A millisecond prescaler counts clock cycles, and after a fixed number of milliseconds the wait is abandoned with an error code that tells a send from a receive. The acknowledge input is asynchronous and passes through a two-stage synchronizer before the sequencer uses it.

Top module: `hs_byte_xcvr`

## Requirements
- R1: After reset, reqN is 1, busy is 0, done is 0 and errCode is 2'b00.
- R2: A command is accepted only when cmdValid is 1 while busy is 0. cmdRead=0 selects a send of cmdData and cmdRead=1 selects a receive. cmdValid while busy is 1 has no effect: no extra transfer and no extra done pulse.
- R3: Before request is driven, acknowledge must be seen high. If it stays low for the whole timeout, the command fails and reqN never goes low.
- R4: During a send, dirOut is 1 and shiftOut equals the accepted byte, both held stable while reqN is 0. reqN stays 0 until acknowledge is seen low, then returns to 1, and done pulses with errCode 2'b00.
- R5: During a receive, dirOut is 0. reqN is released once acknowledge is seen low. rspData takes shiftIn only after acknowledge has returned high, so a value present while acknowledge is low is never reported.
- R6: Each acknowledge wait ends in an error after TIMEOUT_MS times CYC_PER_MS cycles. When the free check fails, done rises that many cycles (within one) after the accepting clock edge.
- R7: errCode is valid with done. 2'b00 means success, 2'b01 means a send failed and 2'b10 means a receive failed. The value 2'b11 never appears.
- R8: Whenever done is 1, reqN is 1 and busy is 0. A command presented in that same cycle is accepted.
- R9: done is a single-cycle pulse, one per accepted command. errCode and rspData hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdRead | input | 1 | 1 = receive, 0 = send |
| cmdData | input | 8 | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | 00 ok, 01 send error, 10 receive error |
| rspData | output | 8 | Last received byte |
| reqN | output | 1 | Active-low request to peripheral |
| dirOut | output | 1 | 1 = shift register driven by host |
| shiftOut | output | 8 | Data presented to the shift register |
| shiftIn | input | 8 | Shift register contents from peripheral |
| ackIn | input | 1 | Asynchronous acknowledge from peripheral |

## Verification
Two functions can coincide on one clock edge: the completion of one transfer, which returns the block to idle, and the acceptance of the next command. The bench provokes this by raising cmdValid in the very cycle it observes done. It judges the result by busy rising on the next edge, with reqN high and the code of the finished transfer intact. A second collision is a command strobe arriving mid-transfer. The bench confirms at the peripheral side that this strobe produced neither a second request nor a second done pulse, and that the byte being sent was not disturbed.

// File: rtl/hs_xcvr_pkg.sv
package hs_xcvr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_FREE = 2'd1,
    ST_WAIT_LOW  = 2'd2,
    ST_WAIT_HIGH = 2'd3
  } ctlState_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_SEND = 2'b01,
    ERR_RECV = 2'b10
  } errCode_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latchCmd;
    logic startReq;
    logic releaseReq;
    logic capture;
    logic finishOk;
    logic finishErr;
    logic errIsRecv;
  } dpStrobe_t;

endpackage

// File: rtl/hs_xcvr_ctrl.sv
module hs_xcvr_ctrl
  import hs_xcvr_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int TIMEOUT_MS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdRead,
  input  logic      ackSync,
  output logic      busy,
  output dpStrobe_t strb
);

  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int MS_W  = (TIMEOUT_MS > 1) ? $clog2(TIMEOUT_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(TIMEOUT_MS - 1);

  ctlState_e        state, stateNxt;
  logic             isRead;
  logic [PRE_W-1:0] presc;
  logic [MS_W-1:0]  msCnt;
  logic             clrTimer;
  logic             timeUp;

  assign timeUp = (presc == PRE_LAST) && (msCnt == MS_LAST);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    clrTimer = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          strb.latchCmd = 1'b1;
          stateNxt      = ST_WAIT_FREE;
          clrTimer      = 1'b1;
        end
      end
      ST_WAIT_FREE: begin
        if (ackSync) begin
          strb.startReq = 1'b1;
          stateNxt      = ST_WAIT_LOW;
          clrTimer      = 1'b1;
        end else if (timeUp) begin
          strb.finishErr = 1'b1;
          strb.errIsRecv = isRead;
          stateNxt       = ST_IDLE;
        end
      end
      ST_WAIT_LOW: begin
        if (!ackSync) begin
          strb.releaseReq = 1'b1;
          clrTimer        = 1'b1;
          if (isRead) begin
            stateNxt = ST_WAIT_HIGH;
          end else begin
            strb.finishOk = 1'b1;
            stateNxt      = ST_IDLE;
          end
        end else if (timeUp) begin
          strb.finishErr = 1'b1;
          strb.errIsRecv = isRead;
          stateNxt       = ST_IDLE;
        end
      end
      ST_WAIT_HIGH: begin
        if (ackSync) begin
          strb.capture  = 1'b1;
          strb.finishOk = 1'b1;
          stateNxt      = ST_IDLE;
        end else if (timeUp) begin
          strb.finishErr = 1'b1;
          strb.errIsRecv = 1'b1;
          stateNxt       = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strb.latchCmd) isRead <= cmdRead;
    end
  end

  // millisecond prescaler and millisecond counter, cleared per wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
      msCnt <= '0;
    end else if (clrTimer || state == ST_IDLE) begin
      presc <= '0;
      msCnt <= '0;
    end else if (presc == PRE_LAST) begin
      presc <= '0;
      msCnt <= msCnt + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  // R6: a wait never outlives its window without ending
  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_IDLE && timeUp) |=> (state == ST_IDLE || $past(clrTimer)));

endmodule

// File: rtl/hs_xcvr_datapath.sv
module hs_xcvr_datapath
  import hs_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              cmdRead,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              ackAsync,
  input  logic [DATA_W-1:0] shiftIn,
  output logic              ackSync,
  output logic              reqN,
  output logic              dirOut,
  output logic [DATA_W-1:0] shiftOut,
  output logic [DATA_W-1:0] rspData,
  output logic              done,
  output logic [1:0]        errCode
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DATA_W-1:0]      dataQ;
  logic                   readQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= ackAsync;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ackAsync};
      end
    end
  endgenerate

  assign ackSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ    <= '0;
      readQ    <= 1'b0;
      reqN     <= 1'b1;
      dirOut   <= 1'b0;
      shiftOut <= '0;
      rspData  <= '0;
      done     <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      done <= 1'b0;
      if (strb.latchCmd) begin
        dataQ <= cmdData;
        readQ <= cmdRead;
      end
      if (strb.startReq) begin
        reqN   <= 1'b0;
        dirOut <= !readQ;
        if (!readQ) shiftOut <= dataQ;
      end
      if (strb.releaseReq || strb.finishErr) reqN <= 1'b1;
      if (strb.capture) rspData <= shiftIn;
      if (strb.finishOk) begin
        done    <= 1'b1;
        errCode <= ERR_NONE;
      end
      if (strb.finishErr) begin
        done    <= 1'b1;
        errCode <= strb.errIsRecv ? ERR_RECV : ERR_SEND;
      end
    end
  end

  // R4: direction and data do not move while request is asserted
  a_r4_bus_stable_under_req: assert property (@(posedge clk) disable iff (!rstN)
    (!reqN && $past(!reqN)) |-> ($stable(dirOut) && $stable(shiftOut)));

endmodule

// File: rtl/hs_byte_xcvr.sv
module hs_byte_xcvr
  import hs_xcvr_pkg::*;
#(
  parameter int CYC_PER_MS  = 50000,
  parameter int TIMEOUT_MS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdRead,
  input  logic [7:0] cmdData,
  output logic       busy,
  output logic       done,
  output logic [1:0] errCode,
  output logic [7:0] rspData,
  output logic       reqN,
  output logic       dirOut,
  output logic [7:0] shiftOut,
  input  logic [7:0] shiftIn,
  input  logic       ackIn
);

  localparam int DATA_W = 8;

  dpStrobe_t strb;
  logic      ackSync;

  hs_xcvr_ctrl #(
    .CYC_PER_MS(CYC_PER_MS),
    .TIMEOUT_MS(TIMEOUT_MS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdRead  (cmdRead),
    .ackSync  (ackSync),
    .busy     (busy),
    .strb     (strb)
  );

  hs_xcvr_datapath #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdRead  (cmdRead),
    .cmdData  (cmdData),
    .ackAsync (ackIn),
    .shiftIn  (shiftIn),
    .ackSync  (ackSync),
    .reqN     (reqN),
    .dirOut   (dirOut),
    .shiftOut (shiftOut),
    .rspData  (rspData),
    .done     (done),
    .errCode  (errCode)
  );

  // R8: request released and sequencer idle whenever done shows
  a_r8_done_req_released: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (reqN && !busy));

  // R8: request never asserted while idle
  a_r8_idle_req_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> reqN);

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: unused code never reported
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode != 2'b11));

endmodule

// File: tb/hs_byte_xcvr_bench.sv
module hs_byte_xcvr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 4;
  localparam int TMO        = 32;
  localparam int WIN        = CYC * TMO;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdRead = 1'b0;
  logic [7:0] cmdData = '0;
  logic       busy, done, reqN, dirOut;
  logic [1:0] errCode;
  logic [7:0] rspData, shiftOut;
  logic [7:0] shiftIn = 8'hEE;
  logic       ackIn = 1'b1;

  int checks = 0;
  int fails  = 0;

  // peripheral model state
  int         mode = 0;  // 0 normal, 1 stuck low, 2 stuck high, 3 low never returns
  logic [7:0] rxByte = 8'h00;
  logic [2:0] reqDly = 3'b111;
  int         reqLowCycles = 0;
  int         doneCount = 0;
  logic       seenDir = 1'b0;
  logic [7:0] seenByte = '0;
  int         lat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_byte_xcvr #(.CYC_PER_MS(CYC), .TIMEOUT_MS(TMO)) u_hs_byte_xcvr (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdData(cmdData), .busy(busy), .done(done), .errCode(errCode),
    .rspData(rspData), .reqN(reqN), .dirOut(dirOut), .shiftOut(shiftOut),
    .shiftIn(shiftIn), .ackIn(ackIn)
  );

  always @(posedge clk) begin : periph
    logic nxt;
    reqDly <= {reqDly[1:0], reqN};
    case (mode)
      1:       nxt = 1'b0;
      2:       nxt = 1'b1;
      3:       nxt = ackIn ? reqDly[2] : 1'b0;
      default: nxt = reqDly[2];
    endcase
    ackIn <= nxt;
    if (ackIn && !nxt)      shiftIn <= 8'hEE;
    else if (!ackIn && nxt) shiftIn <= rxByte;
    if (!reqN) begin
      reqLowCycles <= reqLowCycles + 1;
      seenDir      <= dirOut;
      seenByte     <= shiftOut;
    end
    if (done) doneCount <= doneCount + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // issue a command, wait for done; lat = edges from accept to done
  task automatic runCmd(input logic rd, input logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = rd; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 0;
    while (!done && lat < 4*WIN) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    check(reqN === 1'b1, "R1 reqN", reqN, 1);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(done === 1'b0, "R1 done", done, 0);
    check(errCode === 2'b00, "R1 errCode", errCode, 0);
  endtask

  task automatic t_send(input logic [7:0] d);
    int low0;
    mode = 0;
    low0 = reqLowCycles;
    runCmd(1'b0, d);
    check(done === 1'b1, "R4 send done", done, 1);
    check(errCode === 2'b00, "R4 send ok", errCode, 0);
    check(seenByte === d, "R4 byte at peripheral", seenByte, d);
    check(seenDir === 1'b1, "R4 dir out", seenDir, 1);
    check(reqLowCycles > low0, "R4 req asserted", reqLowCycles - low0, 1);
    check(reqN === 1'b1 && busy === 1'b0, "R8 idle at done", {reqN, busy}, 2'b10);
  endtask

  task automatic t_recv(input logic [7:0] d);
    mode = 0;
    rxByte = d;
    runCmd(1'b1, 8'h11);
    check(done === 1'b1, "R5 recv done", done, 1);
    check(errCode === 2'b00, "R5 recv ok", errCode, 0);
    check(rspData === d, "R5 data after ack high", rspData, d);
    check(seenDir === 1'b0, "R5 dir in", seenDir, 0);
    repeat (5) @(negedge clk);
    check(rspData === d, "R9 rspData held", rspData, d);
  endtask

  task automatic t_not_free(input logic rd);
    int low0;
    mode = 1;
    repeat (6) @(negedge clk);
    low0 = reqLowCycles;
    runCmd(rd, 8'h77);
    check(done === 1'b1, "R3 done on busy peer", done, 1);
    check(errCode === (rd ? 2'b10 : 2'b01), "R7 code on busy peer", errCode, rd ? 2 : 1);
    check(reqLowCycles == low0, "R3 req never low", reqLowCycles - low0, 0);
    check(lat >= WIN - 1 && lat <= WIN + 1, "R6 timeout latency", lat, WIN);
    repeat (4) @(negedge clk);
    check(errCode === (rd ? 2'b10 : 2'b01), "R9 code held", errCode, rd ? 2 : 1);
    mode = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_no_ack_send;
    mode = 2;
    runCmd(1'b0, 8'h3C);
    check(done === 1'b1 && errCode === 2'b01, "R6 send ack-low timeout", errCode, 1);
    check(lat >= WIN, "R6 send wait full window", lat, WIN);
    check(reqN === 1'b1, "R8 req released after error", reqN, 1);
    mode = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_no_return_recv;
    mode = 3;
    rxByte = 8'h99;
    runCmd(1'b1, 8'h00);
    check(done === 1'b1 && errCode === 2'b10, "R5 recv ack-high timeout", errCode, 2);
    check(rspData !== 8'hEE && rspData !== 8'h99, "R5 no capture on error", rspData, 0);
    check(reqN === 1'b1, "R8 req released after recv error", reqN, 1);
    mode = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_ignore_busy;
    int done0, low0;
    mode = 0;
    done0 = doneCount;
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = 1'b0; cmdData = 8'hA5;
    @(negedge clk);
    cmdValid = 1'b1; cmdRead = 1'b1; cmdData = 8'h5A;  // while busy: R2 ignore
    @(negedge clk);
    cmdValid = 1'b0;
    low0 = 0;
    while (!done && low0 < 4*WIN) begin
      @(negedge clk);
      low0++;
    end
    repeat (30) @(negedge clk);
    check(doneCount - done0 == 1, "R2 one done for one command", doneCount - done0, 1);
    check(seenByte === 8'hA5, "R2 byte unchanged", seenByte, 8'hA5);
    check(busy === 1'b0, "R2 no second transfer", busy, 0);
  endtask

  task automatic t_back_to_back;
    mode = 0;
    rxByte = 8'h42;
    runCmd(1'b0, 8'h81);
    // same cycle as done: new command
    cmdValid = 1'b1; cmdRead = 1'b1; cmdData = 8'h00;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b1, "R8 accept in done cycle", busy, 1);
    check(errCode === 2'b00, "R9 code held into next", errCode, 0);
    lat = 0;
    while (!done && lat < 4*WIN) begin
      @(negedge clk);
      lat++;
    end
    check(done === 1'b1 && rspData === 8'h42, "R8 back-to-back recv", rspData, 8'h42);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_send(8'hA5);
    t_send(8'h00);
    t_send(8'hFF);
    t_recv(8'h5A);
    t_recv(8'hC3);
    t_not_free(1'b0);
    t_not_free(1'b1);
    t_no_ack_send();
    t_no_return_recv();
    t_ignore_busy();
    t_back_to_back();
    summary();
    $finish;
  end

endmodule